// File: doc/BRIEF.md
# Two-Way Instruction Cache with Range Invalidation

This block is a read-only, two-way set-associative cache placed between an instruction fetch port and a memory port that answers one word read at a time. A hit is returned in the same cycle as the request. A miss stalls the fetch, reads the whole eight-word line from memory starting at word 0, and then serves the requested word from the freshly filled line.

Fetches bypass the cache when the enable input is low or when the top address bit is set. In that case a single memory read is made, its data goes straight back to the requester, and no line is allocated. Two maintenance inputs are provided. One drops every line in a single cycle. The other walks an inclusive span of line addresses one line per cycle and removes any resident line that matches. The walk holds the busy output high and stalls fetches until it completes.

Top module: `fetch_icache`

## Requirements
- R1: After a synchronous active-low reset, every line is invalid, `busy`, `m_req` and `f_ack` are low, and the first cached fetch is a miss.
- R2: The fetch address is a word address. Bits [2:0] select the word within an eight-word line, the next IDX_W bits (7 by default, giving 128 sets) select the set, and the remaining TAG_W bits (20 by default) form the tag. Two addresses that share set bits contend for the same two ways.
- R3: An idle cached fetch that hits raises `f_ack` in the same cycle as `f_req`, with the stored word on `f_data` and no memory request.
- R4: A cached miss issues eight memory reads of the line, at word offsets 0 to 7 in that order. Each word completes on one `m_ack`. While a read is waiting for its `m_ack`, `m_req` and `m_addr` stay unchanged. The requested word is acknowledged in the cycle after the eighth word.
- R5: A fetch whose address has the top bit set (word bit 29 by default) makes exactly one memory read of that same address. The data is returned with `f_ack` in the cycle of `m_ack`, and the fetch is never allocated, so repeating it reads memory again.
- R6: While `cache_en` is low, every fetch behaves as in R5 and the cache contents are left as they were.
- R7: Each set keeps one bit that marks its least recently used way. A fill replaces that way, and both a hit and a fill make the other way the least recently used one. At most one way hits.
- R8: A pulse on `inv_all` while idle invalidates every line in one cycle without raising `busy`.
- R9: A pulse on `inv_start` while idle, with `inv_lo_line` <= `inv_hi_line`, raises `busy` for exactly `inv_hi_line - inv_lo_line + 1` cycles. During those cycles it invalidates every resident line whose line address lies in the inclusive span and leaves all other lines untouched. When lo > hi the pulse has no effect.
- R10: `f_ack` stays low while `busy` is high, except for the bypass return of R5. Maintenance inputs are taken only while `busy` is low. In the same idle cycle, `inv_all` has priority over `inv_start`, which has priority over a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | High lets fetches use the cache |
| f_req | input | 1 | Fetch request, held until acknowledged |
| f_addr | input | WA_W | Fetch word address |
| f_ack | output | 1 | Fetch served this cycle |
| f_data | output | DATA_W | Fetched word, valid with f_ack |
| inv_all | input | 1 | Invalidate every line |
| inv_start | input | 1 | Start invalidating a span of lines |
| inv_lo_line | input | WA_W-3 | First line address of the span |
| inv_hi_line | input | WA_W-3 | Last line address of the span |
| busy | output | 1 | Fill, bypass read or span walk in progress |
| m_req | output | 1 | Memory word read request |
| m_addr | output | WA_W | Memory word address |
| m_ack | input | 1 | Memory read completes this cycle |
| m_data | input | DATA_W | Memory read data, valid with m_ack |

## Verification
The assertions rely on the requester holding `f_req` and `f_addr` steady until `f_ack`, on memory answering only while `m_req` is high, and on maintenance pulses arriving only while `busy` is low. The bench drives fetches through a task that keeps the address fixed until it sees the acknowledge. Its memory model raises `m_ack` only against a pending request, after a random delay of zero to two cycles. Maintenance pulses are issued only after a completed fetch has left the block idle. Random fetches are drawn from a few tags and sets, so hits, evictions and set conflicts occur often.

// File: rtl/icache_pkg.sv
// Package: shared types and fixed geometry for the instruction cache.
// Assumes a two-way organisation; the single LRU bit per set depends on it.
package icache_pkg;
    localparam int NWAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_BYP  = 2'd2,
        ST_WALK = 2'd3
    } ic_state_e;
endpackage

// File: rtl/ic_tag_store.sv
// Tag store: valid bits, tags and one LRU bit per set for two ways.
// Looks up one index/tag per cycle. It can clear everything, clear the hit
// ways, or install a new tag. Assumes a fill never targets a line that
// already hits, so at most one way matches.
module ic_tag_store
    import icache_pkg::*;
#(
    parameter int SETS  = 128,
    parameter int IDX_W = 7,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             clr_all,
    input  logic             clr_hit,
    input  logic             touch,
    input  logic             fill_set,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_way,
    output logic [NWAYS-1:0] hit_vec,
    output logic             victim
);
    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  vld_q;

        // valid bits: reset, global clear, walk clear, fill install
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                vld_q <= '0;
            end else begin
                if (clr_hit && hit_vec[w]) vld_q[lk_idx] <= 1'b0;
                if (fill_set && fill_way == 1'(w)) vld_q[fill_idx] <= 1'b1;
            end
        end

        // tag storage written on the last beat of a fill
        always_ff @(posedge clk) begin
            if (fill_set && fill_way == 1'(w)) tag_q[fill_idx] <= fill_tag;
        end

        assign hit_vec[w] = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    end

    // LRU bit: points at the way to replace next
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (fill_set) begin
            lru_q[fill_idx] <= ~fill_way;
        end else if (touch) begin
            lru_q[lk_idx] <= ~hit_vec[1];
        end
    end

    assign victim = lru_q[lk_idx];

    p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hit_vec == '0));
    p_no_high_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_set |-> !fill_tag[TAG_W-1]);
endmodule

// File: rtl/ic_data_store.sv
// Data store: one word array per way, organised as set-major, word-minor.
// One write port is used by the line fill. The read is combinational and
// driven by the lookup address, with the way chosen by the hit vector.
module ic_data_store
    import icache_pkg::*;
#(
    parameter int SETS   = 128,
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 3,
    parameter int DATA_W = 32,
    localparam int WORDS = SETS * (1 << OFF_W)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_way,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] rd_w [NWAYS];

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic [DATA_W-1:0] mem_q [WORDS];

        // fill beat write into this way
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w)) mem_q[{wr_idx, wr_off}] <= wr_data;
        end

        assign rd_w[w] = mem_q[{rd_idx, rd_off}];
    end

    assign rd_data = rd_w[rd_way];
endmodule

// File: rtl/ic_ctrl.sv
// Controller: serves hits, sequences line fills and bypass reads, and walks
// invalidation spans. Assumes f_req/f_addr are held until f_ack and that
// maintenance pulses come only while busy is low.
module ic_ctrl
    import icache_pkg::*;
#(
    parameter int WA_W  = 30,
    parameter int OFF_W = 3,
    localparam int LINE_W = WA_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              f_req,
    input  logic [WA_W-1:0]   f_addr,
    output logic              f_ack,
    output logic              f_from_mem,
    input  logic              inv_all,
    input  logic              inv_start,
    input  logic [LINE_W-1:0] inv_lo_line,
    input  logic [LINE_W-1:0] inv_hi_line,
    output logic              busy,
    input  logic              hit_any,
    input  logic              victim,
    output logic [WA_W-1:0]   lk_addr,
    output logic              clr_all,
    output logic              clr_hit,
    output logic              touch,
    output logic [WA_W-1:0]   fill_addr,
    output logic              dw_en,
    output logic [OFF_W-1:0]  dw_off,
    output logic              fill_set,
    output logic              fill_way,
    output logic              m_req,
    output logic [WA_W-1:0]   m_addr,
    input  logic              m_ack
);
    ic_state_e         state_q;
    logic [WA_W-1:0]   addr_q;
    logic [OFF_W-1:0]  cnt_q;
    logic              way_q;
    logic [LINE_W-1:0] walk_q;
    logic [LINE_W-1:0] end_q;
    logic              uncached;
    logic              idle_fetch;
    logic              last_beat;

    // decode of the current request and phase
    always_comb begin
        uncached   = !cache_en || f_addr[WA_W-1];
        idle_fetch = (state_q == ST_IDLE) && f_req && !inv_all && !inv_start;
        last_beat  = (cnt_q == {OFF_W{1'b1}});
        lk_addr    = (state_q == ST_WALK) ? {walk_q, {OFF_W{1'b0}}} : f_addr;
        touch      = idle_fetch && !uncached && hit_any;
        f_ack      = touch || ((state_q == ST_BYP) && m_ack);
        f_from_mem = (state_q == ST_BYP);
        clr_all    = (state_q == ST_IDLE) && inv_all;
        clr_hit    = (state_q == ST_WALK);
        m_req      = (state_q == ST_FILL) || (state_q == ST_BYP);
        m_addr     = (state_q == ST_FILL) ? {addr_q[WA_W-1:OFF_W], cnt_q} : addr_q;
        dw_en      = (state_q == ST_FILL) && m_ack;
        dw_off     = cnt_q;
        fill_set   = dw_en && last_beat;
        fill_way   = way_q;
        fill_addr  = addr_q;
        busy       = (state_q != ST_IDLE);
    end

    // phase sequencing and captured request state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            cnt_q   <= '0;
            way_q   <= 1'b0;
            walk_q  <= '0;
            end_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (inv_all) begin
                        state_q <= ST_IDLE;
                    end else if (inv_start) begin
                        if (inv_lo_line <= inv_hi_line) begin
                            walk_q  <= inv_lo_line;
                            end_q   <= inv_hi_line;
                            state_q <= ST_WALK;
                        end
                    end else if (f_req) begin
                        if (uncached) begin
                            addr_q  <= f_addr;
                            state_q <= ST_BYP;
                        end else if (!hit_any) begin
                            addr_q  <= f_addr;
                            cnt_q   <= '0;
                            way_q   <= victim;
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (m_ack) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (last_beat) state_q <= ST_IDLE;
                    end
                end
                ST_BYP: begin
                    if (m_ack) state_q <= ST_IDLE;
                end
                default: begin
                    if (walk_q == end_q) state_q <= ST_IDLE;
                    else walk_q <= walk_q + 1'b1;
                end
            endcase
        end
    end

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr)));
    p_walk_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WALK) |-> (walk_q <= end_q));
    p_ack_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        f_ack |-> f_req);
endmodule

// File: rtl/fetch_icache.sv
// Top: two-way instruction cache with global and span invalidation.
// Splits word addresses into tag/set/word fields and wires the controller to
// the tag and data stores. Assumes a held fetch request and one outstanding
// memory read at a time.
module fetch_icache
    import icache_pkg::*;
#(
    parameter int CACHE_BYTES = 8192,
    parameter int LINE_BYTES  = 32,
    parameter int DATA_W      = 32,
    parameter int WA_W        = 30,
    localparam int LINE_WORDS = LINE_BYTES / (DATA_W / 8),
    localparam int OFF_W      = $clog2(LINE_WORDS),
    localparam int SETS       = CACHE_BYTES / NWAYS / LINE_BYTES,
    localparam int IDX_W      = $clog2(SETS),
    localparam int TAG_W      = WA_W - IDX_W - OFF_W,
    localparam int LINE_W     = WA_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              f_req,
    input  logic [WA_W-1:0]   f_addr,
    output logic              f_ack,
    output logic [DATA_W-1:0] f_data,
    input  logic              inv_all,
    input  logic              inv_start,
    input  logic [LINE_W-1:0] inv_lo_line,
    input  logic [LINE_W-1:0] inv_hi_line,
    output logic              busy,
    output logic              m_req,
    output logic [WA_W-1:0]   m_addr,
    input  logic              m_ack,
    input  logic [DATA_W-1:0] m_data
);
    logic [WA_W-1:0]   lk_addr;
    logic [WA_W-1:0]   fill_addr;
    logic [NWAYS-1:0]  hit_vec;
    logic              victim;
    logic              clr_all;
    logic              clr_hit;
    logic              touch;
    logic              dw_en;
    logic [OFF_W-1:0]  dw_off;
    logic              fill_set;
    logic              fill_way;
    logic              f_from_mem;
    logic [DATA_W-1:0] rd_data;

    ic_ctrl #(.WA_W(WA_W), .OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .f_req(f_req), .f_addr(f_addr), .f_ack(f_ack), .f_from_mem(f_from_mem),
        .inv_all(inv_all), .inv_start(inv_start),
        .inv_lo_line(inv_lo_line), .inv_hi_line(inv_hi_line), .busy(busy),
        .hit_any(|hit_vec), .victim(victim), .lk_addr(lk_addr),
        .clr_all(clr_all), .clr_hit(clr_hit), .touch(touch),
        .fill_addr(fill_addr), .dw_en(dw_en), .dw_off(dw_off),
        .fill_set(fill_set), .fill_way(fill_way),
        .m_req(m_req), .m_addr(m_addr), .m_ack(m_ack)
    );

    ic_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_addr[OFF_W +: IDX_W]), .lk_tag(lk_addr[WA_W-1 -: TAG_W]),
        .clr_all(clr_all), .clr_hit(clr_hit), .touch(touch),
        .fill_set(fill_set), .fill_idx(fill_addr[OFF_W +: IDX_W]),
        .fill_tag(fill_addr[WA_W-1 -: TAG_W]), .fill_way(fill_way),
        .hit_vec(hit_vec), .victim(victim)
    );

    ic_data_store #(.SETS(SETS), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .wr_en(dw_en), .wr_way(fill_way),
        .wr_idx(fill_addr[OFF_W +: IDX_W]), .wr_off(dw_off), .wr_data(m_data),
        .rd_way(hit_vec[1]), .rd_idx(lk_addr[OFF_W +: IDX_W]),
        .rd_off(lk_addr[OFF_W-1:0]), .rd_data(rd_data)
    );

    // return path: memory word on bypass, stored word on a hit
    always_comb f_data = f_from_mem ? m_data : rd_data;

    p_stall_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !m_ack) |-> !f_ack);
    p_bypass_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (f_ack && f_from_mem) |=> !m_req);
endmodule

// File: tb/sim_fetch_icache.sv
// Bench: directed corner cases plus seeded random fetches, checked against a
// reference model of the cache contents kept in bench functions.
module sim_fetch_icache;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic        f_req = 1'b0;
    logic [29:0] f_addr = '0;
    logic        f_ack;
    logic [31:0] f_data;
    logic        inv_all = 1'b0;
    logic        inv_start = 1'b0;
    logic [26:0] inv_lo_line = '0;
    logic [26:0] inv_hi_line = '0;
    logic        busy;
    logic        m_req;
    logic [29:0] m_addr;
    logic        m_ack = 1'b0;
    logic [31:0] m_data = '0;

    fetch_icache u0 (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .f_req(f_req),
        .f_addr(f_addr), .f_ack(f_ack), .f_data(f_data), .inv_all(inv_all),
        .inv_start(inv_start), .inv_lo_line(inv_lo_line),
        .inv_hi_line(inv_hi_line), .busy(busy), .m_req(m_req),
        .m_addr(m_addr), .m_ack(m_ack), .m_data(m_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int gen = 1;
    int cyc = 0;
    int log_n = 0;
    int dly = 0;
    logic [29:0] log_a [16];

    // reference model
    bit          mv [2][128];
    logic [19:0] mt [2][128];
    int          mg [2][128];
    bit          ml [128];

    function automatic logic [31:0] mem_fn(logic [29:0] a, int g);
        return {a, 2'b00} ^ (32'(g) * 32'h9E3779B9) ^ 32'h5A5A0F0F;
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic chk(bit ok, string req, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d expected below 150000 cycles", cyc);
            summary();
        end
    end

    // memory responder: one word per request after 0..2 idle cycles
    always @(negedge clk) begin
        if (m_ack) begin
            m_ack = 1'b0;
        end else if (m_req) begin
            if (dly == 0) begin
                m_ack  = 1'b1;
                m_data = mem_fn(m_addr, gen);
                if (log_n < 16) log_a[log_n] = m_addr;
                log_n++;
                dly = int'($urandom % 3);
            end else begin
                dly--;
            end
        end
    end

    task automatic ref_fetch(logic [29:0] a, bit en, output logic [31:0] exp, output int rd);
        int hw = -1;
        int idx = int'(a[9:3]);
        if (!en || a[29]) begin
            rd = 1;
            exp = mem_fn(a, gen);
            return;
        end
        for (int w = 0; w < 2; w++) if (mv[w][idx] && mt[w][idx] == a[29:10]) hw = w;
        if (hw >= 0) begin
            rd = 0;
            exp = mem_fn(a, mg[hw][idx]);
            ml[idx] = (hw == 0);
        end else begin
            int v = int'(ml[idx]);
            mv[v][idx] = 1'b1;
            mt[v][idx] = a[29:10];
            mg[v][idx] = gen;
            ml[idx] = (v == 0);
            rd = 8;
            exp = mem_fn(a, gen);
        end
    endtask

    task automatic do_fetch(logic [29:0] a, bit en, string req);
        logic [31:0] exp;
        logic [31:0] got;
        int rd;
        ref_fetch(a, en, exp, rd);
        @(negedge clk);
        log_n = 0;
        cache_en = en;
        f_req = 1'b1;
        f_addr = a;
        forever begin
            #(CLK_PERIOD/4);
            if (f_ack) begin
                got = f_data;
                break;
            end
            @(negedge clk);
        end
        chk(got == exp, req, "fetch data", got, exp);
        chk(log_n == rd, req, "memory reads", 32'(log_n), 32'(rd));
        if (rd == 8) begin
            for (int i = 0; i < 8; i++)
                chk(log_a[i] == {a[29:3], 3'(i)}, "R4/R2", "fill order", 32'(log_a[i]),
                    32'({a[29:3], 3'(i)}));
        end else if (rd == 1) begin
            chk(log_a[0] == a, "R5", "bypass address", 32'(log_a[0]), 32'(a));
        end
        @(posedge clk);
        @(negedge clk);
        f_req = 1'b0;
        cache_en = 1'b1;
    endtask

    task automatic do_range(logic [26:0] lo, logic [26:0] hi, logic [29:0] hold);
        int cnt = 0;
        int expc = (lo <= hi) ? int'(hi - lo) + 1 : 0;
        @(negedge clk);
        inv_start = 1'b1;
        inv_lo_line = lo;
        inv_hi_line = hi;
        f_req = 1'b1;
        f_addr = hold;
        #(CLK_PERIOD/4);
        chk(!f_ack, "R10", "ack during maintenance pulse", 32'(f_ack), 32'd0);
        @(negedge clk);
        inv_start = 1'b0;
        forever begin
            #(CLK_PERIOD/4);
            if (!busy) break;
            cnt++;
            if (f_ack) chk(1'b0, "R10", "ack while walking", 32'(f_ack), 32'd0);
            @(negedge clk);
        end
        f_req = 1'b0;
        chk(cnt == expc, "R9", "busy cycles of walk", 32'(cnt), 32'(expc));
        if (lo <= hi) begin
            for (logic [27:0] l = {1'b0, lo}; l <= {1'b0, hi}; l++) begin
                int idx = int'(l[6:0]);
                for (int w = 0; w < 2; w++)
                    if (mt[w][idx] == l[26:7]) mv[w][idx] = 1'b0;
            end
        end
    endtask

    task automatic do_inv_all();
        @(negedge clk);
        inv_all = 1'b1;
        #(CLK_PERIOD/4);
        chk(!busy, "R8", "busy on global clear", 32'(busy), 32'd0);
        @(negedge clk);
        inv_all = 1'b0;
        #(CLK_PERIOD/4);
        chk(!busy, "R8", "busy after global clear", 32'(busy), 32'd0);
        for (int s = 0; s < 128; s++) begin
            mv[0][s] = 1'b0;
            mv[1][s] = 1'b0;
        end
    endtask

    function automatic logic [29:0] mk(logic [19:0] t, logic [6:0] s, logic [2:0] o);
        return {t, s, o};
    endfunction

    initial begin
        logic [19:0] tp [3];
        logic [6:0]  sp [4];
        void'($urandom(32'd20240611));
        tp[0] = 20'h00123; tp[1] = 20'h00456; tp[2] = 20'h00789;
        sp[0] = 7'd0; sp[1] = 7'd1; sp[2] = 7'd2; sp[3] = 7'd127;
        for (int s = 0; s < 128; s++) begin
            mv[0][s] = 0; mv[1][s] = 0; ml[s] = 0;
            mt[0][s] = '0; mt[1][s] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        chk(!busy, "R1", "busy after reset", 32'(busy), 32'd0);
        chk(!m_req, "R1", "m_req after reset", 32'(m_req), 32'd0);
        chk(!f_ack, "R1", "f_ack after reset", 32'(f_ack), 32'd0);

        // R1 first fetch misses; R3 neighbour word hits
        do_fetch(mk(tp[0], 7'd5, 3'd6), 1'b1, "R1");
        do_fetch(mk(tp[0], 7'd5, 3'd1), 1'b1, "R3");
        // R7: A,B fill both ways, touch A, C evicts B
        do_fetch(mk(tp[1], 7'd5, 3'd0), 1'b1, "R7");
        do_fetch(mk(tp[0], 7'd5, 3'd7), 1'b1, "R7");
        do_fetch(mk(tp[2], 7'd5, 3'd3), 1'b1, "R7");
        do_fetch(mk(tp[0], 7'd5, 3'd2), 1'b1, "R7");
        do_fetch(mk(tp[1], 7'd5, 3'd2), 1'b1, "R7");
        // R2 same tag, other set is independent
        do_fetch(mk(tp[2], 7'd6, 3'd0), 1'b1, "R2");
        // R5 top bit set: never allocated
        do_fetch(mk(20'h80001, 7'd5, 3'd4), 1'b1, "R5");
        do_fetch(mk(20'h80001, 7'd5, 3'd4), 1'b1, "R5");
        // R6 disabled: bypass, contents untouched
        do_fetch(mk(tp[0], 7'd5, 3'd2), 1'b0, "R6");
        do_fetch(mk(tp[3-1], 7'd9, 3'd2), 1'b0, "R6");
        do_fetch(mk(tp[0], 7'd5, 3'd2), 1'b1, "R6");
        do_fetch(mk(tp[2], 7'd9, 3'd2), 1'b1, "R6");
        // R9 span covering only set 11 line
        do_fetch(mk(tp[0], 7'd10, 3'd0), 1'b1, "R9");
        do_fetch(mk(tp[0], 7'd11, 3'd0), 1'b1, "R9");
        do_fetch(mk(tp[0], 7'd12, 3'd0), 1'b1, "R9");
        gen++;
        do_range({tp[0], 7'd11}, {tp[0], 7'd11}, mk(tp[0], 7'd10, 3'd1));
        do_fetch(mk(tp[0], 7'd10, 3'd4), 1'b1, "R9");
        do_fetch(mk(tp[0], 7'd11, 3'd4), 1'b1, "R9");
        do_fetch(mk(tp[0], 7'd12, 3'd4), 1'b1, "R9");
        // R9 empty span lo > hi, then a wide span
        do_range({tp[0], 7'd12}, {tp[0], 7'd10}, mk(tp[0], 7'd10, 3'd1));
        do_fetch(mk(tp[0], 7'd12, 3'd5), 1'b1, "R9");
        do_range({tp[0], 7'd0}, {tp[0], 7'd127}, mk(tp[0], 7'd10, 3'd1));
        do_fetch(mk(tp[0], 7'd12, 3'd5), 1'b1, "R9");
        // R8 global clear
        gen++;
        do_fetch(mk(tp[1], 7'd20, 3'd0), 1'b1, "R8");
        do_inv_all();
        do_fetch(mk(tp[1], 7'd20, 3'd0), 1'b1, "R8");

        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic [29:0] a;
            bit en;
            int r = int'($urandom % 100);
            a = mk(tp[$urandom % 3], sp[$urandom % 4], 3'($urandom));
            if (r < 5) a[29] = 1'b1;
            en = (r >= 5 && r < 12) ? 1'b0 : 1'b1;
            if (i % 60 == 59) begin
                logic [26:0] lo = {tp[$urandom % 3], sp[$urandom % 4]};
                gen++;
                if ($urandom % 4 == 0) do_inv_all();
                else do_range(lo, lo + 27'($urandom % 6), a);
            end else begin
                do_fetch(a, en, "R3/R4/R7 random");
            end
        end
        summary();
    end
endmodule